// File: doc/BRIEF.md
# Debug Clock Output Selector

This block drives one debug clock output pin from a bank of internal clock sources, with a post-divider after the selector. Software writes a single control word. The source index is split across two places in that word: a three-bit low field and a separate high bit. The post-divider code sits in a four-bit field below them. The whole word reads back exactly as it was written. A revision input says whether the die is the newer revision. Sources numbered 8 and above exist only on the newer revision, so on the older revision they are refused.

The source clocks are sampled in the system clock domain. The post-divider passes one full high phase of the chosen source out of every N source periods, where N comes from the divider code. A new selection or divider code is taken over only while the output is low, so no pulse is ever cut short. If the selected index is refused, the output is held low and a sticky error flag is raised. The flag stays set until reset.

Top module: `clkout_sel`

## Requirements
- R1: After reset the control word reads 0. Any value written reads back bit for bit on every cycle after the write.
- R2: The source index is {word[18], word[14:12]}. With divide-by-1, selecting source k repeats the output at the period of source k.
- R3: The divider code is word[11:8]. Codes 0 to 5 divide by code+1, code 6 divides by 10, code 7 divides by 12, and codes 8 to 15 divide by 1.
- R4: Every output pulse is exactly one high phase of the selected source. The output is high only in cycles that follow a high sample of that source.
- R5: An index at or above the number of sources (13 to 15 with defaults) keeps the output low and sets the error flag.
- R6: When the revision input is 0, indexes 8 to 12 are refused (output low, error flag set) and index 7 still works. When the input is 1, those indexes work.
- R7: The active selection changes only in a cycle where the output is low. An output pulse in progress when a new selection is written completes at full width.
- R8: The error flag stays set until reset, even after a valid selection is written.
- R9: During and after reset the output and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Control word readback |
| src_clk | input | NUM_SRC | Source clock levels, one per index |
| rev_new | input | 1 | 1 selects the newer revision, which unlocks indexes 8 and up |
| clk_out | output | 1 | Debug clock output |
| sel_err | output | 1 | Sticky flag for a refused selection |

## Verification
The interesting collision is a new selection that arrives while an output pulse is high. In that case the pending switch has to wait until the divider lets the output fall. The bench provokes this by writing a fast source at the instant the slow source's pulse rises. It then measures every high run that follows: the pulse in flight must last its full slow half-period, and every later run must match one of the two sources exactly, never a fragment. A second collision pairs a revision change with a stored index: the same control word must stop and restart the output as the revision input alone changes.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 4;
  localparam int DIV_W   = 4;
  localparam int CNT_W   = 4;
  localparam int LO_POS  = 12;
  localparam int HI_POS  = 18;
  localparam int DIV_POS = 8;

  typedef logic [IDX_W-1:0] src_idx_t;
  typedef logic [DIV_W-1:0] div_code_t;
  typedef logic [CNT_W-1:0] div_cnt_t;

  // Source index: high bit above the three-bit low field.
  function automatic src_idx_t idx_of(input logic [REG_W-1:0] w);
    return {w[HI_POS], w[LO_POS+2:LO_POS]};
  endfunction

  function automatic div_code_t code_of(input logic [REG_W-1:0] w);
    return w[DIV_POS+DIV_W-1:DIV_POS];
  endfunction

  // Division ratio for a divider code.
  function automatic div_cnt_t ratio_of(input div_code_t c);
    div_cnt_t r;
    if (c < 4'd6)       r = c + 4'd1;
    else if (c == 4'd6) r = 4'd10;
    else if (c == 4'd7) r = 4'd12;
    else                r = 4'd1;
    return r;
  endfunction

  function automatic logic idx_ok(input src_idx_t i, input logic rev_new,
                                  input int unsigned n_src,
                                  input int unsigned n_old);
    return (32'(i) < n_src) && (rev_new || (32'(i) < n_old));
  endfunction
endpackage

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
  import clkout_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned OLD_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             rev_new,
  output logic [REG_W-1:0] rdata,
  output src_idx_t         cfg_idx,
  output div_code_t        cfg_code,
  output logic             cfg_ok,
  output logic             err
);
  logic [REG_W-1:0] word_q;

  assign rdata    = word_q;
  assign cfg_idx  = idx_of(word_q);
  assign cfg_code = code_of(word_q);
  assign cfg_ok   = idx_ok(cfg_idx, rev_new, NUM_SRC, OLD_SRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      err    <= 1'b0;
    end else begin
      if (we) word_q <= wdata;
      if (!cfg_ok) err <= 1'b1;
    end
  end
endmodule

// File: rtl/clkout_src_mux.sv
module clkout_src_mux
  import clkout_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  src_idx_t           act_idx,
  input  logic               act_ok,
  output logic               cur_lvl
);
  localparam int PAD_W = 1 << IDX_W;

  logic [NUM_SRC-1:0] smp_q;
  logic [PAD_W-1:0]   smp_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= src_clk;
  end

  assign smp_pad = PAD_W'(smp_q);
  assign cur_lvl = act_ok & smp_pad[act_idx];
endmodule

// File: rtl/clkout_post_div.sv
module clkout_post_div
  import clkout_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_idx_t  cfg_idx,
  input  div_code_t cfg_code,
  input  logic      cfg_ok,
  input  logic      cur_lvl,
  output src_idx_t  act_idx,
  output logic      act_ok,
  output logic      clk_out,
  output logic      sw_evt,
  output logic      rise_evt
);
  div_code_t act_code;
  div_cnt_t  cnt_q;
  div_cnt_t  ratio;
  logic      prev_q;
  logic      seen_q;
  logic      pending;
  logic      wrap;

  assign pending  = (cfg_idx != act_idx) || (cfg_code != act_code) ||
                    (cfg_ok != act_ok);
  assign sw_evt   = pending && !clk_out;
  assign ratio    = ratio_of(act_code);
  assign wrap     = (cnt_q == ratio - CNT_W'(1));
  assign rise_evt = cur_lvl && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_idx  <= '0;
      act_code <= '0;
      act_ok   <= 1'b0;
      cnt_q    <= '0;
      prev_q   <= 1'b1;
      seen_q   <= 1'b0;
      clk_out  <= 1'b0;
    end else if (sw_evt) begin
      act_idx  <= cfg_idx;
      act_code <= cfg_code;
      act_ok   <= cfg_ok;
      cnt_q    <= ratio_of(cfg_code) - CNT_W'(1);
      prev_q   <= 1'b1;
      seen_q   <= 1'b0;
      clk_out  <= 1'b0;
    end else begin
      prev_q <= cur_lvl;
      if (rise_evt) begin
        cnt_q  <= wrap ? '0 : cnt_q + CNT_W'(1);
        seen_q <= 1'b1;
      end
      clk_out <= cur_lvl && (rise_evt ? wrap : (seen_q && cnt_q == '0));
    end
  end
endmodule

// File: rtl/clkout_sel.sv
module clkout_sel
  import clkout_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned OLD_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               rev_new,
  output logic               clk_out,
  output logic               sel_err
);
  src_idx_t  cfg_idx;
  div_code_t cfg_code;
  logic      cfg_ok;
  src_idx_t  act_idx;
  logic      act_ok;
  logic      cur_lvl;
  logic      sw_evt;
  logic      rise_evt;

  clkout_cfg_reg #(.NUM_SRC(NUM_SRC), .OLD_SRC(OLD_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rev_new(rev_new), .rdata(cfg_rdata), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .cfg_ok(cfg_ok), .err(sel_err)
  );

  clkout_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .act_idx(act_idx),
    .act_ok(act_ok), .cur_lvl(cur_lvl)
  );

  clkout_post_div u_div (
    .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .cfg_ok(cfg_ok), .cur_lvl(cur_lvl), .act_idx(act_idx),
    .act_ok(act_ok), .clk_out(clk_out), .sw_evt(sw_evt),
    .rise_evt(rise_evt)
  );
endmodule

// File: rtl/clkout_sel_chk.sv
module clkout_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        rev_new,
  input logic        clk_out,
  input logic        sel_err,
  input logic [3:0]  act_idx,
  input logic        act_ok,
  input logic        cur_lvl
);
  AST_READBACK_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> (cfg_rdata == $past(cfg_wdata))); // R1
  AST_SWITCH_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_idx != $past(act_idx)) |-> !$past(clk_out)); // R7
  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_ok |=> !clk_out); // R5
  AST_OUT_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> $past(cur_lvl)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err); // R8
  AST_OLD_REV_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rev_new && cfg_rdata[18]) |=> sel_err); // R6
endmodule

bind clkout_sel clkout_sel_chk u_chk (.*);

// File: tb/tb_clkout_sel.sv
module tb_clkout_sel;
  localparam int NSRC = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [31:0]     cfg_wdata = '0;
  logic [31:0]     cfg_rdata;
  logic [NSRC-1:0] src_clk;
  logic            rev_new = 1'b1;
  logic            clk_out;
  logic            sel_err;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // Source k has a half-period of k+2 cycles.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic sb = 1'b0;
    int   c = 0;
    always @(negedge clk) begin
      if (c == g + 1) begin c = 0; sb <= ~sb; end
      else c = c + 1;
    end
    assign src_clk[g] = sb;
  end

  clkout_sel dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int idx, input int code);
    logic [3:0] i = 4'(idx);
    return {13'b0, i[3], 3'b0, i[2:0], 4'(code), 8'b0};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Waits for a fresh rising edge, then measures high width and period.
  task automatic meas(output int per, output int hi);
    logic p = 1'b1;
    per = -1; hi = -1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!p && clk_out) begin
        hi = 0; per = 0;
        for (int m = 0; m < 3000 && clk_out; m++) begin
          hi++; per++; @(negedge clk);
        end
        for (int m = 0; m < 3000 && !clk_out; m++) begin
          per++; @(negedge clk);
        end
        return;
      end
      p = clk_out;
    end
  endtask

  task automatic rises(input int cycles, output int cnt);
    logic p = clk_out;
    cnt = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (!p && clk_out) cnt++;
      p = clk_out;
    end
  endtask

  task automatic t_reset_readback();
    int per, hi;
    chk("R9 out after reset", int'(clk_out), 0);
    chk("R9 err after reset", int'(sel_err), 0);
    chk("R1 word after reset", int'(cfg_rdata == 32'h0), 1);
    wr(32'h5A00_2305);
    chk("R1 readback", int'(cfg_rdata == 32'h5A00_2305), 1);
    meas(per, hi); meas(per, hi);
    chk("R3 code 3 period on source 2", per, 32);
  endtask

  task automatic t_sources();
    int per, hi;
    int ks[4] = '{0, 5, 9, 12};
    foreach (ks[j]) begin
      wr(mk(ks[j], 8));
      meas(per, hi); meas(per, hi);
      chk($sformatf("R2 period source %0d", ks[j]), per, 2 * (ks[j] + 2));
      chk($sformatf("R4 width source %0d", ks[j]), hi, ks[j] + 2);
    end
  endtask

  task automatic t_divider();
    int per, hi;
    int codes[6] = '{0, 4, 6, 7, 8, 15};
    int rat[6]   = '{1, 5, 10, 12, 1, 1};
    foreach (codes[j]) begin
      wr(mk(3, codes[j]));
      meas(per, hi); meas(per, hi);
      chk($sformatf("R3 code %0d period", codes[j]), per, 10 * rat[j]);
      chk($sformatf("R4 code %0d width", codes[j]), hi, 5);
    end
  endtask

  task automatic t_old_rev();
    int per, hi, cnt;
    rev_new = 1'b0;
    wr(mk(7, 8));
    meas(per, hi); meas(per, hi);
    chk("R6 index 7 on old revision", per, 18);
    chk("R6 no error for index 7", int'(sel_err), 0);
    wr(mk(10, 8));
    rises(200, cnt);
    chk("R6 index 10 refused, no pulses", cnt, 0);
    chk("R6 index 10 refused, error", int'(sel_err), 1);
    rev_new = 1'b1;
    meas(per, hi); meas(per, hi);
    chk("R6 index 10 on new revision", per, 24);
    chk("R8 error kept", int'(sel_err), 1);
  endtask

  task automatic t_reserved();
    int per, hi, cnt;
    do_reset();
    chk("R9 err cleared by reset", int'(sel_err), 0);
    wr(mk(13, 8));
    rises(200, cnt);
    chk("R5 index 13 no pulses", cnt, 0);
    chk("R5 index 13 error", int'(sel_err), 1);
    wr(mk(15, 0));
    rises(100, cnt);
    chk("R5 index 15 no pulses", cnt, 0);
    wr(mk(4, 8));
    meas(per, hi); meas(per, hi);
    chk("R8 valid source runs again", per, 12);
    chk("R8 error still set", int'(sel_err), 1);
  endtask

  task automatic t_switch();
    int per, hi, run, first, bad, shorts;
    logic p;
    wr(mk(12, 8));
    meas(per, hi);
    p = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!p && clk_out) break;
      p = clk_out;
    end
    cfg_we = 1'b1; cfg_wdata = mk(0, 8);
    run = 1; first = -1; bad = 0; shorts = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (clk_out) run++;
      else if (run > 0) begin
        if (first < 0) first = run;
        if (run == 2) shorts++;
        else if (run != 14) bad++;
        run = 0;
      end
    end
    chk("R7 pulse in flight at full width", first, 14);
    chk("R7 no runt pulses", bad, 0);
    chk("R7 new source took over", int'(shorts > 0), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 out held in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_readback();
    t_sources();
    t_divider();
    t_old_rev();
    t_reserved();
    t_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule